// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Pair with Trigger Control

This block holds the byte queues that sit between a UART's serial engines and the host bus. The receive queue is filled by the deserializer and drained by host read strobes. The transmit queue is filled by host writes and drained by the serializer. Both queues hold 64 bytes by default and are controlled by a write-only byte-wide configuration port. The host bus decoder sends writes at the shared control/identification address to this port. A write can turn queueing on or off, empty either queue in one cycle, and pick one of four receive fill thresholds.

The block compares the receive fill level against the chosen threshold. It drives a registered interrupt condition, which is gated by an interrupt-enable input, and a registered receive DMA request. When queueing is off, each direction behaves as a single holding byte and the threshold is one byte. A byte that arrives at a full receive queue is dropped, and a sticky overrun flag records the loss.

Top module: `uart_fifo_trig`

## Requirements
- R1: After synchronous reset, both fill levels are 0, both read-data outputs are 0, `rx_irq`, `rx_dma_req` and `rx_overrun` are 0, queueing is off and the trigger code is 00.
- R2: A `cfg_wr` pulse stores `cfg_data[0]` as the queue enable and `cfg_data[7:6]` as the trigger code. Bits 5:3 have no effect.
- R3: `cfg_data[1]`=1 empties the receive queue and clears `rx_overrun` at that write's clock edge. `cfg_data[2]`=1 empties the transmit queue. Neither bit is stored, so a later write without it empties nothing.
- R4: A write that changes the enable bit empties both queues at that edge.
- R5: With queueing on, each queue accepts up to DEPTH (64) bytes and returns them in arrival order.
- R6: With queueing off, each queue holds at most one byte, and the receive threshold is 1 byte regardless of the code.
- R7: A receive push when the level equals capacity is dropped and sets `rx_overrun`, which stays set until a receive clear. A transmit push when full is dropped.
- R8: A pop from an empty queue returns 0 on the read-data output and leaves the level at 0.
- R9: Trigger code 00/01/10/11 selects a threshold of 1, DEPTH/8, DEPTH/4 or DEPTH/2 bytes (1/8/16/32). `rx_irq` is 1 exactly when `rda_int_en` was 1 and the receive level was at or above the threshold at the previous edge.
- R10: `rx_dma_req` is 1 exactly when, at the previous edge, `dma_mode` was 1, queueing was on, the code was not 00 and the receive level was at or above the threshold. Code 00 never raises it.
- R11: A pop moves the head byte to the read-data output at the pop's clock edge, and the level drops at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | Configuration write data |
| dma_mode | input | 1 | Receive DMA operation selected |
| rda_int_en | input | 1 | Receive-data-available interrupt enable |
| rx_push | input | 1 | Deserializer byte valid |
| rx_byte | input | 8 | Deserializer byte |
| rx_pop | input | 1 | Host read strobe for the receive queue |
| rx_dout | output | 8 | Byte from the last receive pop |
| rx_level | output | 7 | Receive fill level |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| rx_irq | output | 1 | Receive-data-available interrupt condition |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_push | input | 1 | Host write strobe for the transmit queue |
| tx_byte | input | 8 | Host write byte |
| tx_pop | input | 1 | Serializer take strobe |
| tx_dout | output | 8 | Byte from the last transmit pop |
| tx_level | output | 7 | Transmit fill level |

## Verification
Fill levels, read data, the overrun flag and configuration clears all change at the clock edge where their strobe is sampled. `rx_irq` and `rx_dma_req` follow one edge later, because they are registered from the level. The bench drives every strobe for one cycle starting at a falling edge and samples at the next falling edge for level, data and overrun. For the interrupt and DMA request it waits one more falling edge. Threshold checks sample one byte below each level and then exactly at it, with an extra idle edge first so that the registered condition from the previous level has settled.

// File: rtl/rxtx_fifo_pkg.sv
`timescale 1ns/1ps
package rxtx_fifo_pkg;
  // receive threshold selection, field at cfg_data[7:6]
  typedef enum logic [1:0] {
    TRIG_MIN     = 2'b00,
    TRIG_EIGHTH  = 2'b01,
    TRIG_QUARTER = 2'b10,
    TRIG_HALF    = 2'b11
  } trig_code_e;

  localparam int CFG_EN_BIT    = 0;
  localparam int CFG_RXCLR_BIT = 1;
  localparam int CFG_TXCLR_BIT = 2;
  localparam int CFG_TRIG_LSB  = 6;
endpackage

// File: rtl/fifo_cfg_reg.sv
`timescale 1ns/1ps
module fifo_cfg_reg
  import rxtx_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       fifo_en,
  output trig_code_e trig,
  output logic       rx_clr,
  output logic       tx_clr
);
  logic       en_change;
  logic [2:0] cfg_unused;

  // reserved field is accepted and dropped
  assign cfg_unused = wdata[5:3];

  assign en_change = wr && (wdata[CFG_EN_BIT] != fifo_en);
  // one-cycle clear pulses, valid only while the strobe is high
  assign rx_clr = (wr && wdata[CFG_RXCLR_BIT]) || en_change;
  assign tx_clr = (wr && wdata[CFG_TXCLR_BIT]) || en_change;

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en <= 1'b0;
      trig    <= TRIG_MIN;
    end else if (wr) begin
      fifo_en <= wdata[CFG_EN_BIT];
      trig    <= trig_code_e'(wdata[CFG_TRIG_LSB +: 2]);
    end
  end

  AST_ENCHG_CLEARS_BOTH: assert property (@(posedge clk) disable iff (rst)
    (fifo_en != $past(fifo_en)) |-> ($past(rx_clr) && $past(tx_clr))); // R4
endmodule

// File: rtl/byte_fifo.sv
`timescale 1ns/1ps
module byte_fifo #(
  parameter int DW        = 8,
  parameter int DEPTH     = 64,
  parameter bit TRACK_OVR = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr,
  input  logic                          single,
  input  logic                          push,
  input  logic [DW-1:0]                 wdata,
  input  logic                          pop,
  output logic [DW-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]    level,
  output logic                          overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] cap;
  logic          can_push, can_pop, do_push, do_pop;

  assign cap      = single ? LW'(1) : LW'(DEPTH);
  assign can_push = (level < cap);
  assign can_pop  = (level != '0);
  assign do_push  = push && can_push && !clr;
  assign do_pop   = pop && can_pop && !clr;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (pop && !clr) begin
      rdata <= can_pop ? mem[rptr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  generate
    if (TRACK_OVR) begin : g_ovr
      logic ovr_q;
      always_ff @(posedge clk) begin
        if (rst || clr)                  ovr_q <= 1'b0;
        else if (push && !can_push)      ovr_q <= 1'b1;
      end
      assign overrun = ovr_q;
    end else begin : g_no_ovr
      assign overrun = 1'b0;
    end
  endgenerate

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH)); // R5
  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    single |-> (level <= LW'(1))); // R6
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (level == '0)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !clr && level == cap) |=> (level == $past(level))); // R7
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !clr && level == '0) |=> (level == '0 && rdata == '0)); // R8
endmodule

// File: rtl/rx_trigger.sv
`timescale 1ns/1ps
module rx_trigger
  import rxtx_fifo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(DEPTH+1)-1:0] level,
  input  logic                       fifo_en,
  input  trig_code_e                 trig,
  input  logic                       int_en,
  input  logic                       dma_mode,
  output logic                       irq,
  output logic                       dma_req
);
  localparam int LW       = $clog2(DEPTH+1);
  localparam int THR_MIN  = 1;
  localparam int THR_8TH  = DEPTH / 8;
  localparam int THR_QTR  = DEPTH / 4;
  localparam int THR_HALF = DEPTH / 2;

  logic [LW-1:0] thr;
  logic          reached;

  always_comb begin
    if (!fifo_en) begin
      thr = LW'(THR_MIN);
    end else begin
      case (trig)
        TRIG_EIGHTH:  thr = LW'(THR_8TH);
        TRIG_QUARTER: thr = LW'(THR_QTR);
        TRIG_HALF:    thr = LW'(THR_HALF);
        default:      thr = LW'(THR_MIN);
      endcase
    end
  end

  assign reached = (level >= thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      irq     <= int_en && reached;
      dma_req <= dma_mode && fifo_en && (trig != TRIG_MIN) && reached;
    end
  end

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(int_en)); // R9
  AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(level) != '0)); // R9
  AST_DMA_NOT_CODE0: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> ($past(trig) != TRIG_MIN && $past(dma_mode) && $past(fifo_en))); // R10
endmodule

// File: rtl/uart_fifo_trig.sv
`timescale 1ns/1ps
module uart_fifo_trig
  import rxtx_fifo_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_wr,
  input  logic [7:0]                 cfg_data,
  input  logic                       dma_mode,
  input  logic                       rda_int_en,
  input  logic                       rx_push,
  input  logic [DW-1:0]              rx_byte,
  input  logic                       rx_pop,
  output logic [DW-1:0]              rx_dout,
  output logic [$clog2(DEPTH+1)-1:0] rx_level,
  output logic                       rx_overrun,
  output logic                       rx_irq,
  output logic                       rx_dma_req,
  input  logic                       tx_push,
  input  logic [DW-1:0]              tx_byte,
  input  logic                       tx_pop,
  output logic [DW-1:0]              tx_dout,
  output logic [$clog2(DEPTH+1)-1:0] tx_level
);
  logic       fifo_en, rx_clr, tx_clr;
  logic       tx_ovr_unused;
  trig_code_e trig;

  fifo_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr      (cfg_wr),
    .wdata   (cfg_data),
    .fifo_en (fifo_en),
    .trig    (trig),
    .rx_clr  (rx_clr),
    .tx_clr  (tx_clr)
  );

  byte_fifo #(.DW(DW), .DEPTH(DEPTH), .TRACK_OVR(1'b1)) u_rxq (
    .clk     (clk),
    .rst     (rst),
    .clr     (rx_clr),
    .single  (!fifo_en),
    .push    (rx_push),
    .wdata   (rx_byte),
    .pop     (rx_pop),
    .rdata   (rx_dout),
    .level   (rx_level),
    .overrun (rx_overrun)
  );

  byte_fifo #(.DW(DW), .DEPTH(DEPTH), .TRACK_OVR(1'b0)) u_txq (
    .clk     (clk),
    .rst     (rst),
    .clr     (tx_clr),
    .single  (!fifo_en),
    .push    (tx_push),
    .wdata   (tx_byte),
    .pop     (tx_pop),
    .rdata   (tx_dout),
    .level   (tx_level),
    .overrun (tx_ovr_unused)
  );

  rx_trigger #(.DEPTH(DEPTH)) u_trig (
    .clk      (clk),
    .rst      (rst),
    .level    (rx_level),
    .fifo_en  (fifo_en),
    .trig     (trig),
    .int_en   (rda_int_en),
    .dma_mode (dma_mode),
    .irq      (rx_irq),
    .dma_req  (rx_dma_req)
  );
endmodule

// File: tb/tb_uart_fifo_trig.sv
`timescale 1ns/1ps
module tb_uart_fifo_trig;
  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_wr = 0;
  logic [7:0] cfg_data = 0;
  logic       dma_mode = 0, rda_int_en = 0;
  logic       rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
  logic [7:0] rx_byte = 0, tx_byte = 0;
  logic [7:0] rx_dout, tx_dout;
  logic [6:0] rx_level, tx_level;
  logic       rx_overrun, rx_irq, rx_dma_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_fifo_trig dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .dma_mode(dma_mode), .rda_int_en(rda_int_en),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_pop(rx_pop), .rx_dout(rx_dout),
    .rx_level(rx_level), .rx_overrun(rx_overrun), .rx_irq(rx_irq),
    .rx_dma_req(rx_dma_req), .tx_push(tx_push), .tx_byte(tx_byte),
    .tx_pop(tx_pop), .tx_dout(tx_dout), .tx_level(tx_level)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [7:0] v);
    cfg_wr = 1; cfg_data = v;
    @(negedge clk);
    cfg_wr = 0; cfg_data = 0;
  endtask

  task automatic rxw(input logic [7:0] b);
    rx_push = 1; rx_byte = b;
    @(negedge clk);
    rx_push = 0;
  endtask

  task automatic txw(input logic [7:0] b);
    tx_push = 1; tx_byte = b;
    @(negedge clk);
    tx_push = 0;
  endtask

  task automatic rxr(output logic [7:0] b);
    rx_pop = 1;
    @(negedge clk);
    rx_pop = 0;
    b = rx_dout;
  endtask

  task automatic txr(output logic [7:0] b);
    tx_pop = 1;
    @(negedge clk);
    tx_pop = 0;
    b = tx_dout;
  endtask

  task automatic t_reset();
    chk("R1 rx_level", rx_level, 0);
    chk("R1 tx_level", tx_level, 0);
    chk("R1 rx_dout", rx_dout, 0);
    chk("R1 tx_dout", tx_dout, 0);
    chk("R1 irq", rx_irq, 0);
    chk("R1 dma", rx_dma_req, 0);
    chk("R1 overrun", rx_overrun, 0);
  endtask

  task automatic t_nonfifo();
    logic [7:0] b;
    rda_int_en = 1; dma_mode = 1;
    rxw(8'hA5);
    chk("R6 rx level one", rx_level, 1);
    @(negedge clk);
    chk("R6 irq at one byte", rx_irq, 1);
    chk("R10 no dma with queue off", rx_dma_req, 0);
    rxw(8'h5A);
    chk("R6 second byte dropped", rx_level, 1);
    chk("R7 overrun set", rx_overrun, 1);
    rxr(b);
    chk("R11 rx head byte", b, 8'hA5);
    chk("R11 level after pop", rx_level, 0);
    txw(8'h11); txw(8'h22);
    chk("R6 tx holds one", tx_level, 1);
    txr(b);
    chk("R6 tx keeps first", b, 8'h11);
    rda_int_en = 0; dma_mode = 0;
  endtask

  task automatic t_fill_drain();
    logic [7:0] b;
    cfg(8'h39); // enable, reserved bits 5:3 set, code 00
    chk("R4 enable change clears overrun", rx_overrun, 0);
    for (int i = 0; i < 64; i++) rxw(8'(i * 3 + 1));
    chk("R5 rx holds 64", rx_level, 64);
    rxw(8'hEE);
    chk("R7 full push dropped", rx_level, 64);
    chk("R7 overrun on full", rx_overrun, 1);
    rda_int_en = 1; dma_mode = 1;
    @(negedge clk); @(negedge clk);
    chk("R2 code still 00 irq", rx_irq, 1);
    chk("R10 code 00 no dma", rx_dma_req, 0);
    rda_int_en = 0; dma_mode = 0;
    for (int i = 0; i < 64; i++) begin
      rxr(b);
      if (b != 8'(i * 3 + 1)) chk("R5 rx order", b, i * 3 + 1);
    end
    chk("R5 rx drained", rx_level, 0);
    chk("R7 overrun sticky", rx_overrun, 1);
    rxr(b);
    chk("R8 empty read zero", b, 0);
    chk("R8 empty level", rx_level, 0);
    txr(b);
    chk("R8 tx empty read zero", b, 0);
    cfg(8'h03);
    chk("R3 rx clear drops overrun", rx_overrun, 0);
  endtask

  task automatic t_thresholds();
    int thr[4] = '{1, 8, 16, 32};
    rda_int_en = 1; dma_mode = 1;
    for (int c = 0; c < 4; c++) begin
      cfg(8'((c << 6) | 3));
      for (int k = 0; k < thr[c] - 1; k++) rxw(8'(k));
      @(negedge clk);
      chk($sformatf("R9 irq below thr code %0d", c), rx_irq, 0);
      chk($sformatf("R10 dma below thr code %0d", c), rx_dma_req, 0);
      rxw(8'hC3);
      @(negedge clk);
      chk($sformatf("R9 irq at thr code %0d", c), rx_irq, 1);
      chk($sformatf("R10 dma at thr code %0d", c), rx_dma_req, (c != 0) ? 1 : 0);
      rda_int_en = 0;
      @(negedge clk);
      chk($sformatf("R9 irq gated code %0d", c), rx_irq, 0);
      rda_int_en = 1;
    end
    dma_mode = 0;
    @(negedge clk);
    chk("R10 dma needs dma_mode", rx_dma_req, 0);
    rda_int_en = 0;
    cfg(8'h03);
  endtask

  task automatic t_clears();
    logic [7:0] b;
    for (int i = 0; i < 5; i++) rxw(8'(i));
    for (int i = 0; i < 3; i++) txw(8'(8'h40 + i));
    cfg(8'h05);
    chk("R3 tx cleared", tx_level, 0);
    chk("R3 rx untouched", rx_level, 5);
    cfg(8'h03);
    chk("R3 rx cleared", rx_level, 0);
    cfg(8'h01);
    rxw(8'h77);
    chk("R3 clear not sticky", rx_level, 1);
    txw(8'h61); txw(8'h62); txw(8'h63);
    txr(b); chk("R5 tx order 0", b, 8'h61);
    txr(b); chk("R5 tx order 1", b, 8'h62);
    chk("R11 tx level after pops", tx_level, 1);
    cfg(8'h00);
    chk("R4 rx cleared on disable", rx_level, 0);
    chk("R4 tx cleared on disable", tx_level, 0);
  endtask

  initial begin
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_nonfifo();
    t_fill_drain();
    t_thresholds();
    t_clears();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule